// File: doc/BRIEF.md
# Host-cleared user interrupt register

This block sits between user logic and the user-interrupt port of a PCIe DMA core. A rising edge on any of its request inputs sets a sticky pending bit for that line. The pending bits, gated by an enable mask, drive the interrupt request lines toward the DMA core. A line keeps its request raised until the DMA core acknowledges it. The pending bit itself stays set until host software clears it.

Host software reaches the block through an AXI4-Lite slave that is mapped into user address space. The handler reads the pending word to find out which lines fired. It then writes ones to the clear word for the lines it has serviced. A third word holds the enable mask.

Top module: `uirq_hold_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit and every `dma_irq_o` line is 0, the enable mask reads all ones, and `s_axil_bvalid` and `s_axil_rvalid` are low.
- R2: A rising edge on `usr_req_i[i]` sets pending bit i at the same clock edge that samples it. Reading word offset 0x0 returns the pending vector in bits [NUM_IRQ-1:0], with bit i for line i. A request held high sets the bit only once and does not set it again after a clear.
- R3: A pending bit stays set until a write to offset 0x4 carries a 1 in that bit position. Bits written as 0 leave their pending bits unchanged (write-one-to-clear).
- R4: When a request edge on line i and a clear of bit i land on the same clock edge, the bit stays set.
- R5: `dma_irq_o[i]` is high exactly when pending bit i is set, mask bit i is 1 and line i has not been acknowledged since its last clear. The mask is written and read at offset 0x8, bits [NUM_IRQ-1:0]. A mask write affects the outputs at the same clock edge as the write handshake.
- R6: A high `dma_ack_i[i]` while `dma_irq_o[i]` is high drops that output at the next edge. The output stays low while the bit remains pending, even if new requests arrive. It rises again only after a clear of bit i followed by a new request edge.
- R7: Every write and every read completes with response OKAY (2'b00). A read of an offset other than 0x0, 0x4 or 0x8 returns 0; offset 0x4 also reads as 0. A write to any offset other than 0x4 or 0x8, including 0x0, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_req_i | input | NUM_IRQ | Interrupt requests from user logic, edge-detected |
| dma_irq_o | output | NUM_IRQ | Interrupt request lines to the DMA core |
| dma_ack_i | input | NUM_IRQ | Per-line acknowledge from the DMA core |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | DATA_W | Write data, full word |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | DATA_W | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |

## Verification
Requests arrive on several lines in the same cycle and in staggered cycles, and some are held high. These patterns show whether latching is edge-based and whether lines stay independent. Clear words with mixed ones and zeros show whether only the addressed bits fall. A clear that lands on the same edge as a new request exercises the set priority. Acknowledge pulses followed by fresh requests, with and without an intervening clear, separate the acknowledge state from the pending state. A seeded random mix of request bursts, clears and mask writes is then compared against a bench model of the pending, mask and acknowledged vectors.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned WORD_PEND = 0;
  localparam int unsigned WORD_CLR  = 1;
  localparam int unsigned WORD_MASK = 2;
  localparam logic [1:0]  RESP_OKAY = 2'b00;
endpackage

// File: rtl/uirq_line_bank.sv
module uirq_line_bank #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [NUM_IRQ-1:0] ack_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_IRQ-1:0] mask_wd_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] req_d, pend_q, served_q, irq_q, mask_q;
  logic [NUM_IRQ-1:0] pend_n, served_n, mask_n;

  assign mask_n = mask_we_i ? mask_wd_i : mask_q;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_line
      logic rise;
      assign rise        = req_i[g] & ~req_d[g];
      // a fresh edge wins over a clear on the same cycle
      assign pend_n[g]   = rise | (pend_q[g] & ~clr_i[g]);
      assign served_n[g] = ~clr_i[g] & (served_q[g] | (ack_i[g] & irq_q[g]));

      always_ff @(posedge clk) begin
        if (rst) begin
          req_d[g]    <= 1'b0;
          pend_q[g]   <= 1'b0;
          served_q[g] <= 1'b0;
          irq_q[g]    <= 1'b0;
        end else begin
          req_d[g]    <= req_i[g];
          pend_q[g]   <= pend_n[g];
          served_q[g] <= served_n[g];
          irq_q[g]    <= pend_n[g] & mask_n[g] & ~served_n[g];
        end
      end

      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(req_i[g]) |=> pend_q[g]); // R2 R4
      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend_q[g] && !clr_i[g]) |=> pend_q[g]); // R3
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_q[g] |-> (pend_q[g] && mask_q[g])); // R5
      AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (irq_q[g] && ack_i[g] && !clr_i[g]) |=> !irq_q[g]); // R6
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_n;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uirq_axil_port.sv
module uirq_axil_port
  import uirq_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  awaddr,
  input  logic               awvalid,
  output logic               awready,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wvalid,
  output logic               wready,
  output logic [1:0]         bresp,
  output logic               bvalid,
  input  logic               bready,
  input  logic [ADDR_W-1:0]  araddr,
  input  logic               arvalid,
  output logic               arready,
  output logic [DATA_W-1:0]  rdata,
  output logic [1:0]         rresp,
  output logic               rvalid,
  input  logic               rready,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] clr_o,
  output logic               mask_we_o,
  output logic [NUM_IRQ-1:0] mask_wd_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic              bvalid_q, rvalid_q, wr_fire, rd_fire, wr_aligned, rd_aligned;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] rdata_q, rd_word;

  assign wr_fire    = awvalid & wvalid & ~bvalid_q;
  assign awready    = wr_fire;
  assign wready     = wr_fire;
  assign wr_idx     = awaddr[ADDR_W-1:2];
  assign wr_aligned = (awaddr[1:0] == 2'b00);

  assign clr_o     = (wr_fire && wr_aligned && wr_idx == IDX_W'(WORD_CLR))
                     ? wdata[NUM_IRQ-1:0] : '0;
  assign mask_we_o = wr_fire && wr_aligned && wr_idx == IDX_W'(WORD_MASK);
  assign mask_wd_o = wdata[NUM_IRQ-1:0];

  always_ff @(posedge clk) begin
    if (rst)          bvalid_q <= 1'b0;
    else if (wr_fire) bvalid_q <= 1'b1;
    else if (bready)  bvalid_q <= 1'b0;
  end

  assign arready    = ~rvalid_q;
  assign rd_fire    = arvalid & ~rvalid_q;
  assign rd_idx     = araddr[ADDR_W-1:2];
  assign rd_aligned = (araddr[1:0] == 2'b00);

  always_comb begin
    rd_word = '0;
    if (rd_aligned && rd_idx == IDX_W'(WORD_PEND))      rd_word[NUM_IRQ-1:0] = pend_i;
    else if (rd_aligned && rd_idx == IDX_W'(WORD_MASK)) rd_word[NUM_IRQ-1:0] = mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rresp  = RESP_OKAY;
  assign rdata  = rdata_q;

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid_q && !bready) |=> bvalid_q); // R7
  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rvalid_q && !rready) |=> (rvalid_q && $stable(rdata_q))); // R7
  AST_NO_CLR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(awvalid && wvalid) |-> (clr_o == '0 && !mask_we_o)); // R7
endmodule

// File: rtl/uirq_hold_ctrl.sv
module uirq_hold_ctrl #(
  parameter int NUM_IRQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] usr_req_i,
  output logic [NUM_IRQ-1:0] dma_irq_o,
  input  logic [NUM_IRQ-1:0] dma_ack_i,
  input  logic [ADDR_W-1:0]  s_axil_awaddr,
  input  logic               s_axil_awvalid,
  output logic               s_axil_awready,
  input  logic [DATA_W-1:0]  s_axil_wdata,
  input  logic               s_axil_wvalid,
  output logic               s_axil_wready,
  output logic [1:0]         s_axil_bresp,
  output logic               s_axil_bvalid,
  input  logic               s_axil_bready,
  input  logic [ADDR_W-1:0]  s_axil_araddr,
  input  logic               s_axil_arvalid,
  output logic               s_axil_arready,
  output logic [DATA_W-1:0]  s_axil_rdata,
  output logic [1:0]         s_axil_rresp,
  output logic               s_axil_rvalid,
  input  logic               s_axil_rready
);
  logic [NUM_IRQ-1:0] pend, mask, clr, mask_wd;
  logic               mask_we;

  uirq_axil_port #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
    .wdata(s_axil_wdata), .wvalid(s_axil_wvalid), .wready(s_axil_wready),
    .bresp(s_axil_bresp), .bvalid(s_axil_bvalid), .bready(s_axil_bready),
    .araddr(s_axil_araddr), .arvalid(s_axil_arvalid), .arready(s_axil_arready),
    .rdata(s_axil_rdata), .rresp(s_axil_rresp), .rvalid(s_axil_rvalid),
    .rready(s_axil_rready),
    .pend_i(pend), .mask_i(mask), .clr_o(clr),
    .mask_we_o(mask_we), .mask_wd_o(mask_wd)
  );

  uirq_line_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk(clk), .rst(rst),
    .req_i(usr_req_i), .ack_i(dma_ack_i), .clr_i(clr),
    .mask_we_i(mask_we), .mask_wd_i(mask_wd),
    .pend_o(pend), .mask_o(mask), .irq_o(dma_irq_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (dma_irq_o == '0 && !s_axil_bvalid && !s_axil_rvalid)); // R1
endmodule

// File: tb/uirq_hold_ctrl_tb.sv
module uirq_hold_ctrl_tb_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic [N-1:0] req = '0, ack = '0, irq;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic awready, wready, bvalid, arready, rvalid;
  logic [DW-1:0] wdata = '0, rdata;
  logic [1:0] bresp, rresp;

  int errors = 0, checks = 0;
  logic [N-1:0] m_pend = '0, m_mask = '1, m_srv = '0;
  logic [DW-1:0] rd;

  always #2 clk = ~clk;

  uirq_hold_ctrl #(.NUM_IRQ(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .usr_req_i(req), .dma_irq_o(irq), .dma_ack_i(ack),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
    .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(bready),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid),
    .s_axil_rready(rready));

  function automatic logic [N-1:0] exp_irq(logic [N-1:0] p, logic [N-1:0] m, logic [N-1:0] s);
    return p & m & ~s;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic axw(logic [AW-1:0] a, logic [DW-1:0] d);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    tick();
    awvalid = 0; wvalid = 0;
    chk("R7 bvalid", {31'd0, bvalid}, 1);
    chk("R7 bresp", {30'd0, bresp}, 0);
    tick();
  endtask

  task automatic axr(logic [AW-1:0] a, output logic [DW-1:0] d);
    araddr = a; arvalid = 1;
    tick();
    arvalid = 0;
    chk("R7 rresp", {30'd0, rresp}, 0);
    d = rdata;
    tick();
  endtask

  task automatic pulse(logic [N-1:0] v);
    req = v; tick(); req = '0; tick();
    m_pend |= v;
  endtask

  task automatic check_state(string tag);
    logic [DW-1:0] r;
    axr(4'h0, r);
    chk({tag, " pend"}, r, DW'(m_pend));
    chk({tag, " irq"}, DW'(irq), DW'(exp_irq(m_pend, m_mask, m_srv)));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 bvalid", {31'd0, bvalid}, 0);
    chk("R1 rvalid", {31'd0, rvalid}, 0);
    axr(4'h8, rd); chk("R1 mask", rd, DW'(4'hF));
    axr(4'h0, rd); chk("R1 pend", rd, 0);

    // R2 overlapping requests
    req = 4'b0101; tick();
    chk("R2 same-edge irq", DW'(irq), DW'(4'b0101));
    req = 4'b0111; tick();
    req = '0; tick();
    m_pend = 4'b0111;
    check_state("R2 overlap");

    // R3 clear subset and zero bits
    axw(4'h4, 32'h5); m_pend &= ~4'h5;
    check_state("R3 subset clear");
    axw(4'h4, 32'h0);
    check_state("R3 zero clear");

    // R2 held level sets once
    req[3] = 1; tick(); tick(); m_pend[3] = 1;
    axw(4'h4, 32'h8); m_pend[3] = 0;
    tick(); tick();
    check_state("R2 held level");
    req[3] = 0; tick();

    // R4 edge and clear on same edge
    pulse(4'b0001);
    req[0] = 0; awaddr = 4'h4; wdata = 32'h1; awvalid = 1; wvalid = 1;
    req[0] = 1; tick();
    awvalid = 0; wvalid = 0; req[0] = 0; tick();
    check_state("R4 set wins");

    // R5 mask
    axw(4'h8, 32'hE); m_mask = 4'hE;
    check_state("R5 masked");
    axr(4'h8, rd); chk("R5 mask readback", rd, DW'(4'hE));
    axw(4'h8, 32'hF); m_mask = 4'hF;
    check_state("R5 unmasked");

    // R6 acknowledge
    chk("R6 pre-ack irq1", DW'(irq[1]), 1);
    ack[1] = 1; tick(); ack[1] = 0; m_srv[1] = 1;
    chk("R6 ack drops", DW'(irq[1]), 0);
    pulse(4'b0010);
    check_state("R6 new req stays low");
    axw(4'h4, 32'h2); m_pend[1] = 0; m_srv[1] = 0;
    check_state("R6 cleared");
    pulse(4'b0010);
    check_state("R6 re-raised");

    // R7 unmapped and read-only offsets
    axr(4'hC, rd); chk("R7 unmapped read", rd, 0);
    axr(4'h4, rd); chk("R7 clear word reads 0", rd, 0);
    axw(4'hC, 32'hFFFF_FFFF);
    axw(4'h0, 32'hFFFF_FFFF);
    check_state("R7 ignored writes");
    axr(4'h8, rd); chk("R7 mask untouched", rd, DW'(4'hF));

    axw(4'h4, 32'hF); m_pend = '0;

    // random mix against model
    for (int it = 0; it < 60; it++) begin
      int op = $urandom_range(0, 2);
      logic [N-1:0] v = N'($urandom);
      if (op == 0) pulse(v);
      else if (op == 1) begin axw(4'h4, DW'(v)); m_pend &= ~v; end
      else begin axw(4'h8, DW'(v)); m_mask = v; end
      check_state("R3 R5 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule